// File: doc/BRIEF.md
# Clock Synthesizer Power-Up Configuration Sequencer

This block brings a jitter-attenuating clock synthesizer out of reset without help from software. Once system reset lifts, it opens one streaming read of a serial SPI EEPROM. That read supplies a count byte followed by that many register address/value pairs. Each pair is written into the synthesizer over a second SPI port. A fixed self-calibration write follows the last pair, and then the block waits for the synthesizer's loss-of-lock flag to clear.

A downstream switch runs from the synthesizer clock, and the block holds that switch in reset until the clock is trustworthy. The late-reset pad is open-drain: the block asserts a pull-low enable from reset onwards. It removes the enable only after loss-of-lock has stayed low for an uninterrupted, programmable number of clock cycles. After that release the sequencer is finished for good. It ignores loss-of-lock, stops driving the synthesizer SPI lines and drops its "loader owns the bus" status, so another host can take the port.

If lock does not arrive within a programmable timeout, the block stops in a fault state. It flags the error and keeps the switch in reset.

Top module: `clksynth_cfg_loader`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy`=1, `done`=0, `error`=0, `late_rst_pull_low`=1, `loader_master`=1, and both `ee_cs_n` and `syn_cs_n` are 1. A reset applied from the fault state clears `error`.
- R2: The EEPROM is read in a single chip-select frame. The frame carries command byte 0x03, then `EE_ADDR_BYTES` address bytes (most significant first) equal to `IMAGE_BASE`, then consecutive bytes. `ee_cs_n` returns high once the last byte of the image has been read.
- R3: The first image byte is a pair count N. N pairs of (register address, register value) follow, and each pair is written to the synthesizer in image order.
- R4: Each synthesizer write takes two 16-bit chip-select frames: {0x00, address} selects the register, then {0x40, value} writes it. `syn_cs_n` stays high for at least `CS_GAP_CYCLES` cycles between frames.
- R5: Both SPI ports use mode 0, MSB first. SCLK is low whenever chip select is high, and MOSI never changes while SCLK is high or on its rising edge.
- R6: After the image, one more write puts `CAL_DATA` (default 0x40) into register `CAL_ADDR` (default 136). This is always the final write. With N=0 it is the only write.
- R7: `late_rst_pull_low` stays 1 until `lol` has been low without a break for `HOLD_CYCLES` cycles after configuration. It then drops to 0, with `done`=1 and `busy`=0.
- R8: Once `late_rst_pull_low` has dropped, it stays 0 and `done` stays 1 whatever `lol` does, and no further synthesizer writes occur.
- R9: `loader_master` is 1 until release and 0 afterwards. Once it is 0, `syn_cs_n`=1, `syn_sclk`=0 and `syn_mosi`=0.
- R10: If `lol` is still high `LOCK_TIMEOUT` cycles after configuration ends, the block sets `error`=1 and clears `busy`. It keeps `done`=0 and `late_rst_pull_low`=1 and issues no further SPI traffic.
- R11: A `lol` pulse during the hold interval cancels it. Release then needs a fresh, complete interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_sclk | output | 1 | EEPROM SPI clock |
| ee_cs_n | output | 1 | EEPROM chip select, active low |
| ee_mosi | output | 1 | EEPROM serial data out |
| ee_miso | input | 1 | EEPROM serial data in |
| syn_sclk | output | 1 | Synthesizer SPI clock |
| syn_cs_n | output | 1 | Synthesizer chip select, active low |
| syn_mosi | output | 1 | Synthesizer serial data out |
| lol | input | 1 | Synthesizer loss-of-lock, high while unlocked |
| late_rst_pull_low | output | 1 | Open-drain enable for the downstream late reset; 1 pulls low, 0 releases |
| loader_master | output | 1 | High while the sequencer owns the synthesizer SPI port |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Late reset released, sequence complete |
| error | output | 1 | Lock timeout fault |

## Verification
The assertions take `lol` to be already synchronous to `clk`. They also take the EEPROM to change `ee_miso` only while `ee_sclk` is low, and `rst_n` to be held low for several cycles at start-up. The bench therefore drives `lol` and `rst_n` only on falling clock edges. Its EEPROM model updates its output only on falling serial-clock edges. The hold-window property counts consecutive low samples of `lol`, so it relies on `lol` being a clean level and not a glitch shorter than a clock.

// File: rtl/cfgload_pkg.sv
`timescale 1ns/1ps
// Shared types for the synthesizer power-up loader.
// Holds the sequencer state encoding and helpers that classify states by
// which serial port they use.
package cfgload_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_EE_CMD,
        ST_EE_ADR,
        ST_EE_CNT,
        ST_EE_RA,
        ST_EE_RD,
        ST_SY_OPA,
        ST_SY_ADR,
        ST_SY_GAPA,
        ST_SY_OPW,
        ST_SY_DAT,
        ST_SY_GAPW,
        ST_WAIT_LOCK,
        ST_HOLD,
        ST_DONE,
        ST_FAULT
    } ld_state_t;

    // True for states that move one byte over the EEPROM port.
    function automatic logic is_ee_byte(ld_state_t s);
        return (s inside {ST_EE_CMD, ST_EE_ADR, ST_EE_CNT, ST_EE_RA, ST_EE_RD});
    endfunction

    // True for states that move one byte over the synthesizer port.
    function automatic logic is_sy_byte(ld_state_t s);
        return (s inside {ST_SY_OPA, ST_SY_ADR, ST_SY_OPW, ST_SY_DAT});
    endfunction

endpackage

// File: rtl/cfgload_spi_byte.sv
`timescale 1ns/1ps
// Single-byte SPI mode-0 shift engine.
// What it does: on a start pulse it shifts eight bits out MSB first while
// capturing eight bits in. SCLK idles low, data is sampled on the rising edge
// and the next bit is presented on the falling edge. The SCLK half period is
// HALF_DIV system clocks. done pulses for one cycle after the last falling edge.
// Assumes: start is only pulsed while the engine is idle; chip select is the
// caller's responsibility.
module cfgload_spi_byte #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    output logic [7:0] rx,
    output logic       done,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          active_q;
    logic          sclk_q;
    logic          done_q;

    // Advance the half-period divider, toggle SCLK and shift both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= tx;
                    bit_q    <= '0;
                    div_q    <= '0;
                    sclk_q   <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign rx   = rx_q;
    assign done = done_q;
    assign sclk = sclk_q;
    assign mosi = sh_q[7];

endmodule

// File: rtl/cfgload_run_timer.sv
`timescale 1ns/1ps
// Saturating run-length timer.
// What it does: counts cycles while run is high and clears whenever run is
// low. reached is high once LIMIT consecutive run cycles have been counted.
// Assumes: LIMIT >= 1.
module cfgload_run_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count consecutive run cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q == CNT_MAX);

endmodule

// File: rtl/clksynth_cfg_loader.sv
`timescale 1ns/1ps
// Power-up configuration sequencer for a clock synthesizer.
// What it does: after reset it reads a count-prefixed address/value image
// from a SPI EEPROM in one streaming frame. It writes each pair to the
// synthesizer as a select-address frame and a write-data frame, then writes
// the calibration trigger last. It waits for loss-of-lock to clear, holds the
// downstream late reset for HOLD_CYCLES of continuous lock and then releases
// it. After release it is terminal: lol is ignored and the synthesizer port
// goes idle. A lock timeout parks it in a fault state with the reset held.
// Assumes: lol is synchronous to clk; one SPI engine is shared by both
// ports because they are never active together.
module clksynth_cfg_loader
    import cfgload_pkg::*;
#(
    parameter int         HALF_DIV      = 4,
    parameter int         EE_ADDR_BYTES = 2,
    parameter int         IMAGE_BASE    = 0,
    parameter int         CS_GAP_CYCLES = 4,
    parameter int         HOLD_CYCLES   = 2_500_000,
    parameter int         LOCK_TIMEOUT  = 12_500_000,
    parameter logic [7:0] CAL_ADDR      = 8'd136,
    parameter logic [7:0] CAL_DATA      = 8'h40,
    parameter logic [7:0] EE_READ_OP    = 8'h03,
    parameter logic [7:0] SET_ADDR_OP   = 8'h00,
    parameter logic [7:0] WRITE_OP      = 8'h40
) (
    input  logic clk,
    input  logic rst_n,
    output logic ee_sclk,
    output logic ee_cs_n,
    output logic ee_mosi,
    input  logic ee_miso,
    output logic syn_sclk,
    output logic syn_cs_n,
    output logic syn_mosi,
    input  logic lol,
    output logic late_rst_pull_low,
    output logic loader_master,
    output logic busy,
    output logic done,
    output logic error
);
    localparam int AW       = 8 * EE_ADDR_BYTES;
    localparam int IW       = $clog2(EE_ADDR_BYTES + 1);
    localparam int GW       = $clog2(CS_GAP_CYCLES + 1);
    localparam int ADR_LAST = EE_ADDR_BYTES - 1;
    localparam logic [AW-1:0] BASE_V   = AW'(IMAGE_BASE);
    localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP_CYCLES - 1);

    ld_state_t     st_q;
    logic          kick_q;
    logic          ee_sel_q;
    logic          cal_q;
    logic [IW-1:0] adr_idx_q;
    logic [GW-1:0] gap_q;
    logic [7:0]    pairs_q;
    logic [7:0]    reg_a_q;
    logic [7:0]    reg_d_q;

    logic [7:0]    eng_tx;
    logic [7:0]    eng_rx;
    logic          eng_done;
    logic          eng_sclk;
    logic          eng_mosi;
    logic [AW-1:0] base_shift;
    logic          lock_tmo;
    logic          hold_ok;
    logic          ee_phase;
    logic          sy_phase;

    assign ee_phase   = is_ee_byte(st_q);
    assign sy_phase   = is_sy_byte(st_q);
    assign base_shift = BASE_V >> (8 * (ADR_LAST - int'(adr_idx_q)));

    // Choose the byte the shared engine sends in the current state.
    always_comb begin
        case (st_q)
            ST_EE_CMD: eng_tx = EE_READ_OP;
            ST_EE_ADR: eng_tx = base_shift[7:0];
            ST_SY_OPA: eng_tx = SET_ADDR_OP;
            ST_SY_ADR: eng_tx = cal_q ? CAL_ADDR : reg_a_q;
            ST_SY_OPW: eng_tx = WRITE_OP;
            ST_SY_DAT: eng_tx = cal_q ? CAL_DATA : reg_d_q;
            default:   eng_tx = 8'h00;
        endcase
    end

    cfgload_spi_byte #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (kick_q),
        .tx    (eng_tx),
        .rx    (eng_rx),
        .done  (eng_done),
        .sclk  (eng_sclk),
        .mosi  (eng_mosi),
        .miso  (ee_miso)
    );

    cfgload_run_timer #(.LIMIT(LOCK_TIMEOUT)) u_lock_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_WAIT_LOCK),
        .reached (lock_tmo)
    );

    cfgload_run_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     ((st_q == ST_HOLD) && !lol),
        .reached (hold_ok)
    );

    // Sequence image fetch, synthesizer writes, lock wait and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_BOOT;
            kick_q    <= 1'b0;
            ee_sel_q  <= 1'b0;
            cal_q     <= 1'b0;
            adr_idx_q <= '0;
            gap_q     <= '0;
            pairs_q   <= '0;
            reg_a_q   <= '0;
            reg_d_q   <= '0;
        end else begin
            kick_q <= 1'b0;
            case (st_q)
                ST_BOOT: begin
                    st_q     <= ST_EE_CMD;
                    ee_sel_q <= 1'b1;
                    kick_q   <= 1'b1;
                end
                ST_EE_CMD: if (eng_done) begin
                    st_q      <= ST_EE_ADR;
                    adr_idx_q <= '0;
                    kick_q    <= 1'b1;
                end
                ST_EE_ADR: if (eng_done) begin
                    if (int'(adr_idx_q) == ADR_LAST) st_q <= ST_EE_CNT;
                    else adr_idx_q <= adr_idx_q + 1'b1;
                    kick_q <= 1'b1;
                end
                ST_EE_CNT: if (eng_done) begin
                    pairs_q <= eng_rx;
                    kick_q  <= 1'b1;
                    if (eng_rx == 8'd0) begin
                        cal_q    <= 1'b1;
                        ee_sel_q <= 1'b0;
                        st_q     <= ST_SY_OPA;
                    end else begin
                        st_q <= ST_EE_RA;
                    end
                end
                ST_EE_RA: if (eng_done) begin
                    reg_a_q <= eng_rx;
                    st_q    <= ST_EE_RD;
                    kick_q  <= 1'b1;
                end
                ST_EE_RD: if (eng_done) begin
                    reg_d_q <= eng_rx;
                    pairs_q <= pairs_q - 8'd1;
                    if (pairs_q == 8'd1) ee_sel_q <= 1'b0;
                    st_q   <= ST_SY_OPA;
                    kick_q <= 1'b1;
                end
                ST_SY_OPA: if (eng_done) begin
                    st_q   <= ST_SY_ADR;
                    kick_q <= 1'b1;
                end
                ST_SY_ADR: if (eng_done) begin
                    st_q  <= ST_SY_GAPA;
                    gap_q <= '0;
                end
                ST_SY_GAPA: begin
                    if (gap_q == GAP_LAST) begin
                        st_q   <= ST_SY_OPW;
                        kick_q <= 1'b1;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_SY_OPW: if (eng_done) begin
                    st_q   <= ST_SY_DAT;
                    kick_q <= 1'b1;
                end
                ST_SY_DAT: if (eng_done) begin
                    st_q  <= ST_SY_GAPW;
                    gap_q <= '0;
                end
                ST_SY_GAPW: begin
                    if (gap_q != GAP_LAST) begin
                        gap_q <= gap_q + 1'b1;
                    end else if (cal_q) begin
                        st_q <= ST_WAIT_LOCK;
                    end else if (pairs_q == 8'd0) begin
                        cal_q  <= 1'b1;
                        st_q   <= ST_SY_OPA;
                        kick_q <= 1'b1;
                    end else begin
                        st_q   <= ST_EE_RA;
                        kick_q <= 1'b1;
                    end
                end
                ST_WAIT_LOCK: begin
                    if (!lol) st_q <= ST_HOLD;
                    else if (lock_tmo) st_q <= ST_FAULT;
                end
                ST_HOLD: begin
                    if (lol) st_q <= ST_WAIT_LOCK;
                    else if (hold_ok) st_q <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    assign ee_cs_n           = !ee_sel_q;
    assign ee_sclk           = eng_sclk & ee_phase;
    assign ee_mosi           = eng_mosi & ee_phase;
    assign syn_cs_n          = !sy_phase;
    assign syn_sclk          = eng_sclk & sy_phase;
    assign syn_mosi          = eng_mosi & sy_phase;
    assign late_rst_pull_low = (st_q != ST_DONE);
    assign loader_master     = (st_q != ST_DONE);
    assign done              = (st_q == ST_DONE);
    assign error             = (st_q == ST_FAULT);
    assign busy              = (st_q != ST_DONE) && (st_q != ST_FAULT);

endmodule

// File: rtl/cfgload_checker.sv
`timescale 1ns/1ps
// Protocol and release checker for the synthesizer loader, bound to the top.
// Assumes lol is synchronous to clk and reset is held for several cycles.
module cfgload_checker #(
    parameter int HOLD_CYCLES = 2_500_000
) (
    input logic clk,
    input logic rst_n,
    input logic ee_sclk,
    input logic ee_cs_n,
    input logic ee_mosi,
    input logic syn_sclk,
    input logic syn_cs_n,
    input logic syn_mosi,
    input logic lol,
    input logic late_rst_pull_low,
    input logic loader_master,
    input logic busy,
    input logic done,
    input logic error
);
    localparam int RW = $clog2(HOLD_CYCLES + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(HOLD_CYCLES);

    logic [RW-1:0] low_run_q;

    // Count consecutive cycles with lol low, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n || lol) low_run_q <= '0;
        else if (low_run_q != RUN_MAX) low_run_q <= low_run_q + 1'b1;
    end

    p_syn_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        syn_cs_n |-> !syn_sclk);
    p_ee_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs_n |-> !ee_sclk);
    p_syn_mosi_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_sclk) |-> $stable(syn_mosi));
    p_syn_mosi_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_sclk && $past(syn_sclk)) |-> $stable(syn_mosi));
    p_ee_mosi_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sclk) |-> $stable(ee_mosi));
    p_hold_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(late_rst_pull_low) |-> (low_run_q == RUN_MAX) && done);
    p_release_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !late_rst_pull_low |=> !late_rst_pull_low && done);
    p_bus_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !loader_master |-> syn_cs_n && !syn_sclk && !syn_mosi);
    p_fault_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> late_rst_pull_low && !done && !busy);

endmodule

bind clksynth_cfg_loader cfgload_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .ee_sclk           (ee_sclk),
    .ee_cs_n           (ee_cs_n),
    .ee_mosi           (ee_mosi),
    .syn_sclk          (syn_sclk),
    .syn_cs_n          (syn_cs_n),
    .syn_mosi          (syn_mosi),
    .lol               (lol),
    .late_rst_pull_low (late_rst_pull_low),
    .loader_master     (loader_master),
    .busy              (busy),
    .done              (done),
    .error             (error)
);

// File: tb/clksynth_cfg_loader_test.sv
`timescale 1ns/1ps
module clksynth_cfg_loader_test;
    localparam int HOLD = 40;
    localparam int TMO  = 200;
    localparam int BASE = 16;
    localparam int GAP  = 3;
    localparam logic [15:0] CAL_WR = 16'h8840;
    localparam int NPAIR = 6;
    // Image pairs {register, value}: loaded into the EEPROM and expected in order at the synthesizer.
    localparam logic [15:0] IMG [0:NPAIR-1] = '{16'h0054, 16'h02A2, 16'h0412,
                                                16'h0B42, 16'h1329, 16'h8A0F};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_miso = 1'b0;
    logic lol = 1'b1;
    logic ee_sclk, ee_cs_n, ee_mosi, syn_sclk, syn_cs_n, syn_mosi;
    logic late_rst_pull_low, loader_master, busy, done, error;

    always #4 clk = ~clk;

    clksynth_cfg_loader #(
        .HALF_DIV(2), .EE_ADDR_BYTES(2), .IMAGE_BASE(BASE), .CS_GAP_CYCLES(GAP),
        .HOLD_CYCLES(HOLD), .LOCK_TIMEOUT(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ee_sclk(ee_sclk), .ee_cs_n(ee_cs_n),
        .ee_mosi(ee_mosi), .ee_miso(ee_miso), .syn_sclk(syn_sclk),
        .syn_cs_n(syn_cs_n), .syn_mosi(syn_mosi), .lol(lol),
        .late_rst_pull_low(late_rst_pull_low), .loader_master(loader_master),
        .busy(busy), .done(done), .error(error)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // EEPROM model: header captured on rising SCLK, data presented on falling SCLK.
    logic [7:0]  mem [0:63];
    logic [23:0] ee_hdr;
    int ee_bits = 0;
    int ee_frames = 0;
    int ee_k;
    always @(negedge ee_cs_n) begin ee_bits = 0; ee_frames++; end
    always @(posedge ee_sclk) if (!ee_cs_n) begin
        if (ee_bits < 24) ee_hdr = {ee_hdr[22:0], ee_mosi};
        ee_bits++;
    end
    always @(negedge ee_sclk) if (!ee_cs_n && ee_bits >= 24) begin
        ee_k = ee_bits - 24;
        ee_miso = mem[(int'(ee_hdr[15:0]) + ee_k / 8) % 64][7 - (ee_k % 8)];
    end

    // Synthesizer model: decodes select-address and write frames into a log.
    logic [15:0] sy_sh;
    logic [7:0]  sy_cur;
    logic [15:0] wr_log [0:31];
    int sy_bits = 0;
    int n_wr = 0;
    int sy_bad = 0;
    bit sy_open = 0;
    bit have_hi = 0;
    time t_hi;
    time min_gap = 64'd1000000;
    always @(negedge syn_cs_n) begin
        sy_bits = 0;
        sy_open = 1;
        if (have_hi && ($time - t_hi) < min_gap) min_gap = $time - t_hi;
    end
    always @(posedge syn_sclk) if (!syn_cs_n) begin
        sy_sh = {sy_sh[14:0], syn_mosi};
        sy_bits++;
    end
    always @(posedge syn_cs_n) if (sy_open) begin
        sy_open = 0;
        have_hi = 1;
        t_hi = $time;
        if (sy_bits != 16) sy_bad++;
        else if (sy_sh[15:8] == 8'h00) sy_cur = sy_sh[7:0];
        else if (sy_sh[15:8] == 8'h40) begin
            if (n_wr < 32) wr_log[n_wr] = {sy_cur, sy_sh[7:0]};
            n_wr++;
        end else sy_bad++;
    end

    // Mode-0 monitor: MOSI must not move while SCLK is high.
    int mosi_viol = 0;
    logic prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n && syn_sclk === 1'b1 && syn_mosi !== prev_mosi) mosi_viol++;
        prev_mosi = syn_mosi;
    end

    task automatic load_image(input int count);
        for (int i = 0; i < 64; i++) mem[i] = 8'hEE;
        mem[BASE] = 8'(count);
        for (int i = 0; i < count; i++) begin
            mem[BASE + 1 + 2 * i] = IMG[i][15:8];
            mem[BASE + 2 + 2 * i] = IMG[i][7:0];
        end
    endtask

    task automatic clear_models();
        n_wr = 0; sy_bad = 0; ee_frames = 0; have_hi = 0;
        min_gap = 64'd1000000; mosi_viol = 0;
    endtask

    task automatic check_reset_state();
        check("R1 busy", busy, 1);
        check("R1 done", done, 0);
        check("R1 error", error, 0);
        check("R1 late reset", late_rst_pull_low, 1);
        check("R1 master", loader_master, 1);
        check("R1 ee cs", ee_cs_n, 1);
        check("R1 syn cs", syn_cs_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Run 1: six-pair image, lock after a blip, then release.
        load_image(NPAIR);
        clear_models();
        repeat (5) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        for (int c = 0; c < 6000 && n_wr < NPAIR + 1; c++) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2 one read frame", ee_frames, 1);
        check("R2 read command", ee_hdr[23:16], 8'h03);
        check("R2 read address", ee_hdr[15:0], BASE);
        check("R2 cs released", ee_cs_n, 1);
        check("R3 write count", n_wr, NPAIR + 1);
        for (int i = 0; i < NPAIR; i++) check("R3 pair in order", wr_log[i], IMG[i]);
        check("R6 calibration last", wr_log[NPAIR], CAL_WR);
        check("R4 frame format", sy_bad, 0);
        check("R4 cs gap", (min_gap >= GAP * 8) ? 1 : 0, 1);
        check("R5 mosi stable", mosi_viol, 0);
        check("R7 held while unlocked", late_rst_pull_low, 1);
        check("R9 master during load", loader_master, 1);
        lol = 1'b0;
        repeat (20) @(negedge clk);
        lol = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 blip keeps reset", late_rst_pull_low, 1);
        check("R11 not done", done, 0);
        lol = 1'b0;
        repeat (HOLD - 3) @(negedge clk);
        check("R7 still held", late_rst_pull_low, 1);
        repeat (8) @(negedge clk);
        check("R7 released", late_rst_pull_low, 0);
        check("R7 done", done, 1);
        check("R7 busy low", busy, 0);
        check("R9 master dropped", loader_master, 0);
        check("R9 syn idle", {syn_cs_n, syn_sclk, syn_mosi}, 3'b100);
        lol = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 stays released", late_rst_pull_low, 0);
        check("R8 done kept", done, 1);
        check("R8 no new writes", n_wr, NPAIR + 1);

        // Run 2: empty image, lock never arrives.
        rst_n = 1'b0;
        load_image(0);
        clear_models();
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        for (int c = 0; c < 3000 && n_wr < 1; c++) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R6 only calibration", n_wr, 1);
        check("R6 calibration value", wr_log[0], CAL_WR);
        check("R2 count zero closes read", ee_cs_n, 1);
        repeat (TMO + 20) @(negedge clk);
        check("R10 error", error, 1);
        check("R10 reset held", late_rst_pull_low, 1);
        check("R10 not done", done, 0);
        check("R10 not busy", busy, 0);
        check("R10 no more writes", n_wr, 1);
        check("R10 syn idle", syn_cs_n, 1);

        // Reset out of the fault state.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        finish_run();
    end
endmodule